// File: doc/BRIEF.md
# Packed Depth/Stencil Pixel Word Access Unit

This block takes single-pixel read and write requests from a pixel pipeline and turns them into accesses on a 32-bit little-endian memory port. It handles the formats that pack more than one quantity into one memory word: 16-bit depth, 24-bit depth in a shared word, combined 24-bit depth with 8-bit stencil, and stencil alone. It also handles 32-bit colour words. For two of these colour layouts the alpha byte is undefined in memory and is filled with all ones when the word is read.

A write that changes only part of a shared word runs a read, merge and write-back sequence with fixed field masks. This applies to a depth-only write into a 24-bit depth word and to a stencil-only write. Whole-word writes and halfword depth writes go to memory in a single write, using byte enables, with no read first.

An external generator supplies the address as a halfword address. The host side can present data in big-endian byte order. In that case the unit swaps bytes on the way in and on the way out. One request is in flight at a time, and completion is signalled by a single-cycle `done` pulse.

Top module: `pxw_access`

## Requirements
- R1: After reset, `done` and `mem_req` are low.
- R2: A request is taken only in the idle state. A `req_valid` raised while an operation is in progress is ignored and leaves memory unchanged.
- R3: `done` is high for exactly one cycle. Call the rising edge that samples an accepted request the acceptance edge, and let L be the number of edges from the edge that samples a memory read request to the edge that samples `mem_rvalid`. `done` is high in the cycle after:
  - the 1st edge past the acceptance edge, for a direct write;
  - the (L+1)th edge past it, for a read;
  - the (L+3)th edge past it, for a partial write.
- R4: Format code 2 (depth 23:0 with stencil 31:24) writes the full 32-bit value with no memory read, and reads return the full word.
- R5: Format code 1 (24-bit depth) writes with a read-merge-write that keeps bits 31:24 of the stored word and replaces bits 23:0. Reads return the word ANDed with 0x00FFFFFF.
- R6: Format code 3 (stencil only) writes with a read-merge-write that keeps bits 23:0 and places write-data bits 7:0 into bits 31:24. Reads return stored bits 31:24 in bits 7:0, with bits 31:8 zero.
- R7: Format code 0 (16-bit depth) accesses one halfword with no merge and no read on writes. Halfword address bit 0 = 0 selects word bits 15:0 (byte enables 0011), and 1 selects bits 31:16 (byte enables 1100). Reads return the halfword zero-extended.
- R8: Reads with format code 4 OR in 0xFF000000, and reads with code 5 OR in 0x000000FF. Codes 6 and 7 read and write the plain word. Codes 4 to 7 write the full word with no read.
- R9: With `host_be` high, write data is byte-swapped before storing and read results are byte-swapped after format handling. The swap covers all 4 bytes for codes 1, 2 and 4 to 7, and the low 2 bytes for code 0. There is no swap for code 3.
- R10: `mem_addr` is the halfword address shifted right by one. Writes of every code except 0 use byte enables 1111.
- R11: Depth-only and stencil-only writes to the same word, in any interleaving, each leave the other field as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_be | input | 1 | Host data is big-endian (sampled with the request) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fmt | input | 3 | Pixel format code |
| req_haddr | input | HADDR_W | Halfword address |
| req_wdata | input | 32 | Write value, host byte order |
| rd_data | output | 32 | Read result, valid while done is high |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | HADDR_W-1 | Memory word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Each result has a fixed due time. A direct write completes one edge after acceptance, a read after L+1 edges, and a partial write after L+3 edges, with the bench memory set to L = 2. The bench counts falling-edge samples from the request until `done` appears and compares that count with the expected value for the operation's kind. It checks that `done` is gone at the next sample. Read data and the stored memory word are compared at the sample where `done` is seen, because the final write lands on the edge that raises `done`.

// File: rtl/pxw_pkg.sv
package pxw_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES_W = WORD_W / 8;

    typedef enum logic [2:0] {
        FMT_Z16   = 3'd0,
        FMT_Z24   = 3'd1,
        FMT_Z24S8 = 3'd2,
        FMT_S8    = 3'd3,
        FMT_XRGB  = 3'd4,
        FMT_BGRX  = 3'd5,
        FMT_ARGB  = 3'd6
    } fmt_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_MERGE = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } state_e;

    localparam logic [WORD_W-1:0] DEPTH24_MASK = 32'h00FF_FFFF;
    localparam logic [WORD_W-1:0] STEN_MASK    = 32'hFF00_0000;
    localparam logic [WORD_W-1:0] HI_FILL      = 32'hFF00_0000;
    localparam logic [WORD_W-1:0] LO_FILL      = 32'h0000_00FF;

endpackage

// File: rtl/pxw_bswap.sv
module pxw_bswap #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign dout[8*g +: 8] = din[8*(BYTES-1-g) +: 8];
    end
endmodule

// File: rtl/pxw_wr_prep.sv
module pxw_wr_prep
    import pxw_pkg::*;
(
    input  fmt_e                fmt,
    input  logic                hbe,
    input  logic                half_sel,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   wval,
    output logic [WORD_W-1:0]   keep,
    output logic [BYTES_W-1:0]  be,
    output logic                rmw
);
    logic [WORD_W-1:0] sw32;
    logic [15:0]       sw16;
    logic [WORD_W-1:0] v32;
    logic [15:0]       v16;

    pxw_bswap #(.BYTES(4)) u_sw32 (.din(wdata),       .dout(sw32));
    pxw_bswap #(.BYTES(2)) u_sw16 (.din(wdata[15:0]), .dout(sw16));

    assign v32 = hbe ? sw32 : wdata;
    assign v16 = hbe ? sw16 : wdata[15:0];

    always_comb begin
        wval = v32;
        keep = '0;
        be   = '1;
        rmw  = 1'b0;
        case (fmt)
            FMT_Z16: begin
                wval = {v16, v16};
                be   = half_sel ? 4'b1100 : 4'b0011;
            end
            FMT_Z24: begin
                wval = v32 & DEPTH24_MASK;
                keep = STEN_MASK;
                rmw  = 1'b1;
            end
            FMT_S8: begin
                wval = {wdata[7:0], 24'h0};
                keep = DEPTH24_MASK;
                rmw  = 1'b1;
            end
            default: begin
                wval = v32;
            end
        endcase
    end
endmodule

// File: rtl/pxw_rd_fmt.sv
module pxw_rd_fmt
    import pxw_pkg::*;
(
    input  fmt_e              fmt,
    input  logic              hbe,
    input  logic              half_sel,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] dout
);
    logic [15:0]       half;
    logic [15:0]       half_sw;
    logic [WORD_W-1:0] val32;
    logic [WORD_W-1:0] val_sw;

    assign half = half_sel ? word[31:16] : word[15:0];

    always_comb begin
        case (fmt)
            FMT_Z24:  val32 = word & DEPTH24_MASK;
            FMT_XRGB: val32 = word | HI_FILL;
            FMT_BGRX: val32 = word | LO_FILL;
            default:  val32 = word;
        endcase
    end

    pxw_bswap #(.BYTES(2)) u_sw16 (.din(half),  .dout(half_sw));
    pxw_bswap #(.BYTES(4)) u_sw32 (.din(val32), .dout(val_sw));

    always_comb begin
        case (fmt)
            FMT_Z16: dout = {16'h0, hbe ? half_sw : half};
            FMT_S8:  dout = {24'h0, word[31:24]};
            default: dout = hbe ? val_sw : val32;
        endcase
    end
endmodule

// File: rtl/pxw_access.sv
module pxw_access
    import pxw_pkg::*;
#(
    parameter int HADDR_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_be,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [2:0]         req_fmt,
    input  logic [HADDR_W-1:0] req_haddr,
    input  logic [31:0]        req_wdata,
    output logic [31:0]        rd_data,
    output logic               done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [HADDR_W-2:0] mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata
);
    localparam int WA_W = HADDR_W - 1;

    typedef struct packed {
        state_e               st;
        logic                 issued;
        logic                 wr;
        fmt_e                 fmt;
        logic                 a1;
        logic                 hbe;
        logic                 rmw;
        logic [WA_W-1:0]      wa;
        logic [BYTES_W-1:0]   be;
        logic [WORD_W-1:0]    wval;
        logic [WORD_W-1:0]    keep;
        logic [WORD_W-1:0]    word;
        logic [WORD_W-1:0]    cap;
        logic [WORD_W-1:0]    rd;
    } regs_t;

    regs_t r_q, r_d;

    logic [WORD_W-1:0]  prep_wval, prep_keep, fmt_out;
    logic [BYTES_W-1:0] prep_be;
    logic               prep_rmw;

    pxw_wr_prep u_prep (
        .fmt      (fmt_e'(req_fmt)),
        .hbe      (host_be),
        .half_sel (req_haddr[0]),
        .wdata    (req_wdata),
        .wval     (prep_wval),
        .keep     (prep_keep),
        .be       (prep_be),
        .rmw      (prep_rmw)
    );

    pxw_rd_fmt u_rdf (
        .fmt      (r_q.fmt),
        .hbe      (r_q.hbe),
        .half_sel (r_q.a1),
        .word     (mem_rdata),
        .dout     (fmt_out)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '1;
        mem_wdata = r_q.word;
        case (r_q.st)
            S_IDLE: begin
                r_d.issued = 1'b0;
                if (req_valid) begin
                    r_d.wr   = req_write;
                    r_d.fmt  = fmt_e'(req_fmt);
                    r_d.a1   = req_haddr[0];
                    r_d.hbe  = host_be;
                    r_d.wa   = req_haddr[HADDR_W-1:1];
                    r_d.wval = prep_wval;
                    r_d.keep = prep_keep;
                    r_d.be   = prep_be;
                    r_d.rmw  = req_write && prep_rmw;
                    r_d.word = prep_wval;
                    if (req_write && !prep_rmw) r_d.st = S_WRITE;
                    else                        r_d.st = S_READ;
                end
            end
            S_READ: begin
                mem_req    = !r_q.issued;
                r_d.issued = 1'b1;
                if (r_q.issued && mem_rvalid) begin
                    r_d.cap  = mem_rdata;
                    r_d.word = mem_rdata;
                    r_d.rd   = fmt_out;
                    r_d.st   = r_q.wr ? S_MERGE : S_DONE;
                end
            end
            S_MERGE: begin
                r_d.word = (r_q.word & r_q.keep) | r_q.wval;
                r_d.st   = S_WRITE;
            end
            S_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                mem_be  = r_q.be;
                r_d.st  = S_DONE;
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr = r_q.wa;
    assign done     = (r_q.st == S_DONE);
    assign rd_data  = r_q.rd;

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && !mem_we));

    // R5 R6 R11
    rmw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && r_q.rmw) |-> (((mem_wdata ^ r_q.cap) & r_q.keep) == '0));

    // R4 R7 R8
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !r_q.rmw) |-> $past(r_q.st == S_IDLE));

    // R6
    sten_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.wr && r_q.fmt == FMT_S8) |-> (rd_data[31:8] == '0));

    // R8
    alpha_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.wr && r_q.fmt == FMT_XRGB && !r_q.hbe) |-> (rd_data[31:24] == 8'hFF));

    // R7
    half_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && r_q.fmt == FMT_Z16) |-> ($countones(mem_be) == 2));

endmodule

// File: tb/pxw_access_test.sv
module pxw_access_test;
    localparam int HW  = 15;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_be = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_fmt = 3'd0;
    logic [HW-1:0] req_haddr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data, mem_wdata, mem_rdata;
    logic done, mem_req, mem_we, mem_rvalid;
    logic [HW-2:0] mem_addr;
    logic [3:0] mem_be;

    int total = 0, bad = 0;
    int nreads = 0, nwrites = 0;
    logic [3:0] last_be;

    always #4 clk = ~clk;

    pxw_access #(.HADDR_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .host_be(host_be), .req_valid(req_valid),
        .req_write(req_write), .req_fmt(req_fmt), .req_haddr(req_haddr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // behavioural memory, read latency LAT
    logic [31:0] bmem [64];
    logic [31:0] exp_mem [64];
    logic        pv [LAT];
    logic [31:0] pd [LAT];

    function automatic logic [31:0] init_word(int i);
        return 32'h9E37_79B9 * (i + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bmem[i] <= init_word(i);
            for (int i = 0; i < LAT; i++) begin pv[i] <= 1'b0; pd[i] <= '0; end
        end else begin
            if (mem_req && mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) bmem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
                nwrites <= nwrites + 1;
                last_be <= mem_be;
            end
            if (mem_req && !mem_we) nreads <= nreads + 1;
            pv[0] <= mem_req && !mem_we;
            pd[0] <= bmem[mem_addr[5:0]];
            for (int i = LAT - 1; i > 0; i--) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
        end
    end
    assign mem_rvalid = pv[LAT-1];
    assign mem_rdata  = pd[LAT-1];

    function automatic logic [31:0] sw32(logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
    function automatic logic [15:0] sw16(logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic logic [31:0] exp_write(logic [31:0] old, logic [2:0] f,
                                              logic a1, logic [31:0] wd, logic be);
        logic [31:0] v;
        logic [15:0] h;
        v = be ? sw32(wd) : wd;
        h = be ? sw16(wd[15:0]) : wd[15:0];
        case (f)
            3'd0: return a1 ? {h, old[15:0]} : {old[31:16], h};
            3'd1: return {old[31:24], v[23:0]};
            3'd3: return {wd[7:0], old[23:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [31:0] w, logic [2:0] f,
                                             logic a1, logic be);
        logic [31:0] v;
        logic [15:0] h;
        h = a1 ? w[31:16] : w[15:0];
        case (f)
            3'd0: return {16'h0, be ? sw16(h) : h};
            3'd3: return {24'h0, w[31:24]};
            3'd1: v = {8'h0, w[23:0]};
            3'd4: v = {8'hFF, w[23:0]};
            3'd5: v = {w[31:8], 8'hFF};
            default: v = w;
        endcase
        return be ? sw32(v) : v;
    endfunction

    function automatic string ftag(logic [2:0] f);
        case (f)
            3'd0: return "R7";
            3'd1: return "R5";
            3'd2: return "R4";
            3'd3: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [31:0] last_rd;

    task automatic do_op(logic wr, logic [2:0] f, logic [HW-1:0] ha, logic [31:0] wd,
                         logic be, bit inject, string tg);
        int r0, w0, n, exp_n, exp_r;
        int idx;
        bit part;
        idx  = int'(ha[6:1]);
        part = wr && (f == 3'd1 || f == 3'd3);
        r0 = nreads; w0 = nwrites;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_fmt = f; req_haddr = ha;
        req_wdata = wd; host_be = be;
        @(negedge clk);
        if (inject) begin
            req_write = 1'b1; req_fmt = 3'd2; req_wdata = 32'hDEAD_BEEF; host_be = 1'b0;
        end else req_valid = 1'b0;
        n = 1;
        while (!done && n < 60) begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
        end
        exp_n = !wr ? LAT + 2 : (part ? LAT + 4 : 2);
        chk({tg, " R3 latency"}, n, exp_n);
        last_rd = rd_data;
        exp_r = (!wr || part) ? 1 : 0;
        chk({tg, " read count"}, nreads - r0, exp_r);
        chk({tg, " write count"}, nwrites - w0, wr ? 1 : 0);
        if (wr) begin
            exp_mem[idx] = exp_write(exp_mem[idx], f, ha[0], wd, be);
            chk({tg, " ", ftag(f), " R10 stored word"}, bmem[idx], exp_mem[idx]);
            if (f != 3'd0) chk({tg, " R10 byte enables"}, {28'h0, last_be}, 32'hF);
        end else begin
            chk({tg, " ", ftag(f), " read"}, rd_data, exp_read(exp_mem[idx], f, ha[0], be));
        end
        @(negedge clk);
        chk({tg, " R3 pulse width"}, {31'h0, done}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", {31'h0, done}, 32'h0);
        chk("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);

        // directed: combined write then depth/stencil interleaving (word 3)
        do_op(1, 3'd2, 15'd6, 32'h1122_3344, 0, 0, "dir");
        chk("R4 literal", bmem[3], 32'h1122_3344);
        do_op(1, 3'd1, 15'd6, 32'hABCD_EF12, 0, 0, "dir");
        chk("R5 R11 depth keeps stencil", bmem[3], 32'h11CD_EF12);
        do_op(1, 3'd3, 15'd6, 32'h0000_005A, 0, 0, "dir");
        chk("R6 R11 stencil keeps depth", bmem[3], 32'h5ACD_EF12);
        do_op(0, 3'd3, 15'd6, 0, 0, 0, "dir");
        chk("R6 stencil read literal", last_rd, 32'h0000_005A);
        do_op(0, 3'd1, 15'd6, 0, 0, 0, "dir");
        chk("R5 depth read literal", last_rd, 32'h00CD_EF12);
        do_op(1, 3'd1, 15'd6, 32'h0012_3456, 0, 0, "dir");
        do_op(1, 3'd3, 15'd6, 32'h0000_00C3, 0, 0, "dir");
        chk("R11 interleave end", bmem[3], 32'hC312_3456);

        // colour alpha fill
        do_op(1, 3'd6, 15'd8, 32'h1234_5678, 0, 0, "dir");
        do_op(0, 3'd4, 15'd8, 0, 0, 0, "dir");
        chk("R8 alpha high fill", last_rd, 32'hFF34_5678);
        do_op(0, 3'd5, 15'd8, 0, 0, 0, "dir");
        chk("R8 alpha low fill", last_rd, 32'h1234_56FF);

        // halfword depth
        do_op(1, 3'd2, 15'd10, 32'h1122_3344, 0, 0, "dir");
        do_op(1, 3'd0, 15'd11, 32'h0000_BEEF, 0, 0, "dir");
        chk("R7 upper halfword", bmem[5], 32'hBEEF_3344);
        chk("R7 byte enables", {28'h0, last_be}, 32'hC);
        do_op(0, 3'd0, 15'd10, 0, 0, 0, "dir");
        chk("R7 lower read", last_rd, 32'h0000_3344);

        // host byte order
        do_op(1, 3'd2, 15'd12, 32'h1122_3344, 1, 0, "dir");
        chk("R9 swapped store", bmem[6], 32'h4433_2211);
        do_op(0, 3'd0, 15'd12, 0, 1, 0, "dir");
        chk("R9 halfword swap", last_rd, 32'h0000_1122);

        // request while busy is ignored
        do_op(1, 3'd3, 15'd14, 32'h0000_0077, 0, 1, "busy");
        chk("R2 ignored request", bmem[7], exp_mem[7]);
        do_op(1, 3'd1, 15'd14, 32'h0055_6677, 0, 1, "busy");
        do_op(0, 3'd2, 15'd14, 0, 0, 0, "busy");
        chk("R2 word after busy injects", last_rd, exp_mem[7]);

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [2:0] f;
            logic [HW-1:0] ha;
            ha = '0;
            f = 3'($urandom_range(0, 7));
            ha[4:0] = 5'($urandom);
            do_op(1'($urandom), f, ha, $urandom, 1'($urandom), ($urandom_range(0, 9) == 0), "rnd");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule